// File: doc/BRIEF.md
# Memory Protection Security Policy Register

This block holds the machine-level security policy for a region-based memory protection unit. It stores three policy bits: a lock-bypass enable, a deny-by-default flag for machine-mode accesses that hit no region, and a machine lockdown flag. It also guards the write path of the per-region configuration and address registers. Alongside the policy register it keeps one lock bit per region. These lock bits are captured from configuration writes, and their OR forms a single "some region is locked" flag.

CSR writes arrive as a single-cycle request made of a write strobe, a 12-bit address and a 32-bit data word. A write to the policy address updates the policy bits under their stickiness rules. A write to a region's configuration or address slot raises that region's write-enable output in the same cycle, but only if the region is unlocked or the bypass is active. The register banks that sit downstream use those enables. The permission check itself belongs to another block.

Top module: `secpol_csr`

## Requirements
- R1: After reset all three policy bits are 0, every region lock bit is 0 and the any-locked flag is 0.
- R2: The deny-by-default bit (write data bit 1) becomes 1 when a policy write carries a 1. After that, policy writes with a 0 leave it at 1 until reset.
- R3: The lockdown bit (write data bit 0) becomes 1 when a policy write carries a 1. After that, policy writes with a 0 leave it at 1 until reset.
- R4: A policy write that asks for the bypass bit (write data bit 2) is ignored while the bypass is 0 and any region is locked. In every other case the bypass bit takes the written value, so clearing it is always honoured.
- R5: While the bypass is 0, a write to a locked region's configuration or address slot produces no write enable, and the region's lock bit is unchanged.
- R6: While the bypass is 1, writes to a locked region's configuration and address slots raise that region's write enable. A configuration write then loads the new lock bit, which allows the lock to be removed.
- R7: A permitted configuration write loads the region's lock bit from write data bit 7. The lock output and the any-locked flag (OR of all lock bits) show the new value from the clock edge that takes the write.
- R8: A write to any address other than the policy address, or a cycle without the write strobe, leaves the policy bits unchanged.
- R9: When the address is the policy address, the read data carries lockdown in bit 0, deny-by-default in bit 1 and bypass in bit 2, with every other bit 0. At any other address the read data is 0.
- R10: Region configuration slots sit at CFG_BASE+i and address slots at ADDR_BASE+i. A write raises at most one enable, and only the enable of the addressed slot, in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | Policy register read data |
| rlb_o | output | 1 | Lock-bypass policy bit |
| mmwp_o | output | 1 | Deny-by-default policy bit |
| mml_o | output | 1 | Machine lockdown policy bit |
| region_cfg_we_o | output | NREG | Per-region configuration write enable |
| region_addr_we_o | output | NREG | Per-region address write enable |
| region_locked_o | output | NREG | Per-region lock bit |
| any_locked_o | output | 1 | OR of all region lock bits |

## Verification
The hardest case to reach from the ports is the bypass being set while a region is locked, because the bypass cannot be raised once a lock exists. The stimulus therefore raises the bypass first and locks a region afterwards. It then tries to unlock and rewrite that region. The same ordering runs with the bypass clear, so both sides of the lock gate are compared. A sweep over all eight starting policy values and all eight follow-up writes, with and without a locked region, covers every stickiness transition.

// File: rtl/secpol_pkg.sv
package secpol_pkg;
  localparam int unsigned POL_MML_BIT  = 0;
  localparam int unsigned POL_MMWP_BIT = 1;
  localparam int unsigned POL_RLB_BIT  = 2;
  localparam int unsigned CFG_LOCK_BIT = 7;

  typedef struct packed {
    logic rlb;
    logic mmwp;
    logic mml;
  } pol_t;
endpackage

// File: rtl/secpol_decode.sv
module secpol_decode #(
  parameter int unsigned       NREG      = 4,
  parameter int unsigned       AW        = 12,
  parameter logic [AW-1:0]     SEC_ADDR  = 12'h747,
  parameter logic [AW-1:0]     CFG_BASE  = 12'h3A0,
  parameter logic [AW-1:0]     ADDR_BASE = 12'h3B0
) (
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  output logic            sec_sel_o,
  output logic            sec_wr_o,
  output logic [NREG-1:0] cfg_hit_o,
  output logic [NREG-1:0] addr_hit_o
);
  assign sec_sel_o = (addr_i == SEC_ADDR);
  assign sec_wr_o  = we_i && sec_sel_o;

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    localparam logic [AW-1:0] CfgA = CFG_BASE + AW'(i);
    localparam logic [AW-1:0] AdrA = ADDR_BASE + AW'(i);
    assign cfg_hit_o[i]  = we_i && (addr_i == CfgA);
    assign addr_hit_o[i] = we_i && (addr_i == AdrA);
  end
endmodule

// File: rtl/secpol_bits.sv
module secpol_bits
  import secpol_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sec_wr_i,
  input  logic wr_rlb_i,
  input  logic wr_mmwp_i,
  input  logic wr_mml_i,
  input  logic any_locked_i,
  output pol_t pol_o
);
  pol_t pol_q, pol_d;

  always_comb begin
    pol_d      = pol_q;
    pol_d.mmwp = pol_q.mmwp | wr_mmwp_i;
    pol_d.mml  = pol_q.mml  | wr_mml_i;
    if (wr_rlb_i && !pol_q.rlb && any_locked_i) begin
      pol_d.rlb = 1'b0;
    end else begin
      pol_d.rlb = wr_rlb_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q <= '0;
    end else if (sec_wr_i) begin
      pol_q <= pol_d;
    end
  end

  assign pol_o = pol_q;

  a_r2_mmwp_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pol_q.mmwp |=> pol_q.mmwp);
  a_r3_mml_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pol_q.mml |=> pol_q.mml);
  a_r4_no_bypass_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pol_q.rlb && any_locked_i) |=> !pol_q.rlb);
  a_r8_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_wr_i |=> $stable(pol_q));
endmodule

// File: rtl/secpol_lock_gate.sv
module secpol_lock_gate #(
  parameter int unsigned NREG = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREG-1:0] cfg_hit_i,
  input  logic [NREG-1:0] addr_hit_i,
  input  logic            rlb_i,
  input  logic            lock_wbit_i,
  output logic [NREG-1:0] cfg_we_o,
  output logic [NREG-1:0] addr_we_o,
  output logic [NREG-1:0] locked_o,
  output logic            any_locked_o
);
  logic [NREG-1:0] locked_q, locked_d, open_v;

  assign open_v    = ~locked_q | {NREG{rlb_i}};
  assign cfg_we_o  = cfg_hit_i  & open_v;
  assign addr_we_o = addr_hit_i & open_v;

  always_comb begin
    locked_d = locked_q;
    for (int i = 0; i < NREG; i++) begin
      if (cfg_we_o[i]) locked_d[i] = lock_wbit_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= '0;
    end else if (|cfg_we_o) begin
      locked_q <= locked_d;
    end
  end

  assign locked_o     = locked_q;
  assign any_locked_o = |locked_q;

  for (genvar i = 0; i < NREG; i++) begin : g_chk
    a_r5_lock_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (locked_q[i] && !rlb_i) |=> locked_q[i]);
    a_r6_bypass_edit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rlb_i && cfg_hit_i[i]) |=> (locked_q[i] == $past(lock_wbit_i)));
  end

  a_r10_single_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cfg_we_o, addr_we_o}));
endmodule

// File: rtl/secpol_csr.sv
module secpol_csr
  import secpol_pkg::*;
#(
  parameter int unsigned   NREG      = 4,
  parameter logic [11:0]   SEC_ADDR  = 12'h747,
  parameter logic [11:0]   CFG_BASE  = 12'h3A0,
  parameter logic [11:0]   ADDR_BASE = 12'h3B0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [31:0]     csr_wdata_i,
  output logic [31:0]     csr_rdata_o,
  output logic            rlb_o,
  output logic            mmwp_o,
  output logic            mml_o,
  output logic [NREG-1:0] region_cfg_we_o,
  output logic [NREG-1:0] region_addr_we_o,
  output logic [NREG-1:0] region_locked_o,
  output logic            any_locked_o
);
  logic            sec_sel, sec_wr, any_locked;
  logic [NREG-1:0] cfg_hit, addr_hit;
  pol_t            pol;
  logic            unused_wdata;

  assign unused_wdata = ^{csr_wdata_i[31:8], csr_wdata_i[6:3]};

  secpol_decode #(
    .NREG(NREG), .AW(12), .SEC_ADDR(SEC_ADDR),
    .CFG_BASE(CFG_BASE), .ADDR_BASE(ADDR_BASE)
  ) u_decode (
    .we_i(csr_we_i), .addr_i(csr_addr_i),
    .sec_sel_o(sec_sel), .sec_wr_o(sec_wr),
    .cfg_hit_o(cfg_hit), .addr_hit_o(addr_hit)
  );

  secpol_bits u_bits (
    .clk_i(clk_i), .rst_ni(rst_ni), .sec_wr_i(sec_wr),
    .wr_rlb_i(csr_wdata_i[POL_RLB_BIT]),
    .wr_mmwp_i(csr_wdata_i[POL_MMWP_BIT]),
    .wr_mml_i(csr_wdata_i[POL_MML_BIT]),
    .any_locked_i(any_locked), .pol_o(pol)
  );

  secpol_lock_gate #(.NREG(NREG)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cfg_hit_i(cfg_hit), .addr_hit_i(addr_hit),
    .rlb_i(pol.rlb), .lock_wbit_i(csr_wdata_i[CFG_LOCK_BIT]),
    .cfg_we_o(region_cfg_we_o), .addr_we_o(region_addr_we_o),
    .locked_o(region_locked_o), .any_locked_o(any_locked)
  );

  always_comb begin
    csr_rdata_o = '0;
    if (sec_sel) begin
      csr_rdata_o[POL_RLB_BIT]  = pol.rlb;
      csr_rdata_o[POL_MMWP_BIT] = pol.mmwp;
      csr_rdata_o[POL_MML_BIT]  = pol.mml;
    end
  end

  assign rlb_o        = pol.rlb;
  assign mmwp_o       = pol.mmwp;
  assign mml_o        = pol.mml;
  assign any_locked_o = any_locked;
endmodule

// File: tb/tb_secpol_csr.sv
module tb_secpol_csr;
  localparam int          NREG = 4;
  localparam logic [11:0] SEC  = 12'h747;
  localparam logic [11:0] CFGB = 12'h3A0;
  localparam logic [11:0] ADRB = 12'h3B0;

  logic            clk, rst_n, we;
  logic [11:0]     addr;
  logic [31:0]     wdata, rdata;
  logic            rlb, mmwp, mml, anyl;
  logic [NREG-1:0] cfg_we, addr_we, locked;

  logic            m_rlb, m_mmwp, m_mml;
  logic [NREG-1:0] m_lock;
  int checks = 0;
  int fails  = 0;

  secpol_csr #(.NREG(NREG), .SEC_ADDR(SEC), .CFG_BASE(CFGB), .ADDR_BASE(ADRB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(we), .csr_addr_i(addr),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .rlb_o(rlb), .mmwp_o(mmwp),
    .mml_o(mml), .region_cfg_we_o(cfg_we), .region_addr_we_o(addr_we),
    .region_locked_o(locked), .any_locked_o(anyl)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_state();
    chk("R4 bypass bit", 32'(rlb), 32'(m_rlb));
    chk("R2 deny-by-default bit", 32'(mmwp), 32'(m_mmwp));
    chk("R3 lockdown bit", 32'(mml), 32'(m_mml));
    chk("R7 lock bits", 32'(locked), 32'(m_lock));
    chk("R7 any-locked flag", 32'(anyl), 32'(|m_lock));
    chk("R9 readback", rdata, {29'd0, m_rlb, m_mmwp, m_mml});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; we = 1'b0; addr = SEC; wdata = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_rlb = 1'b0; m_mmwp = 1'b0; m_mml = 1'b0; m_lock = '0;
    #1;
    check_state();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [NREG-1:0] e_cfg, e_adr;
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    #1;
    for (int i = 0; i < NREG; i++) begin
      e_cfg[i] = (a == CFGB + 12'(i)) && (!m_lock[i] || m_rlb);
      e_adr[i] = (a == ADRB + 12'(i)) && (!m_lock[i] || m_rlb);
    end
    chk("R5/R6/R10 cfg enables", 32'(cfg_we), 32'(e_cfg));
    chk("R5/R6/R10 addr enables", 32'(addr_we), 32'(e_adr));
    if (a == SEC) begin
      m_mml  = m_mml | d[0];
      m_mmwp = m_mmwp | d[1];
      if (!(d[2] && !m_rlb && (|m_lock))) m_rlb = d[2];
    end
    for (int i = 0; i < NREG; i++) if (e_cfg[i]) m_lock[i] = d[7];
    @(negedge clk);
    we = 1'b0; addr = SEC; wdata = '0;
    #1;
    check_state();
  endtask

  initial begin
    rst_n = 1'b0; we = 1'b0; addr = SEC; wdata = '0;
    // R1: reset state
    do_reset();

    // R2 R3 R4 sweep: every start value, every follow-up, with/without a lock
    for (int lk = 0; lk < 2; lk++) begin
      for (int s = 0; s < 8; s++) begin
        for (int w = 0; w < 8; w++) begin
          do_reset();
          wr(SEC, 32'(s));
          if (lk == 1) wr(CFGB, 32'h80);
          wr(SEC, 32'(w));
        end
      end
    end

    // R5 R6 R7: lock each region, try edits with bypass clear and set
    for (int r = 0; r < NREG; r++) begin
      for (int b = 0; b < 2; b++) begin
        do_reset();
        if (b == 1) wr(SEC, 32'h4);
        wr(CFGB + 12'(r), 32'h80);
        wr(ADRB + 12'(r), 32'h1234);
        wr(CFGB + 12'(r), 32'h00);
        wr(ADRB + 12'(r), 32'h5678);
        wr(CFGB + 12'((r + 1) % NREG), 32'h80);
        wr(SEC, 32'h0);
        wr(SEC, 32'h4);
      end
    end

    // R8: other address and idle strobe leave policy alone
    do_reset();
    wr(SEC, 32'h3);
    wr(12'h300, 32'hFFFF_FFFF);
    wr(CFGB + 12'(NREG), 32'hFFFF_FFFF);
    @(negedge clk);
    we = 1'b0; addr = SEC; wdata = 32'h7;
    @(negedge clk);
    #1;
    chk("R8 no strobe bypass", 32'(rlb), 32'd0);
    chk("R8 no strobe readback", rdata, 32'h3);

    // R9: other address reads zero
    addr = 12'h300;
    #1;
    chk("R9 other address reads zero", rdata, 32'd0);
    addr = SEC;
    #1;
    chk("R9 policy readback", rdata, 32'h3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule